// File: doc/BRIEF.md
# Debug Register Access Controller

This block owns a bank of debug registers reached through a 3-bit index. It serves one access at a time: a read or a write to one of four breakpoint slot addresses, the debug status register or the debug control register. The core sends a request on a valid/ready channel and gets back a response with read data and an exception code. The block decides whether the access is legal, whether it traps, and whether it changes state.

Indices 4 and 5 have two meanings, chosen by the `de_mode` input. With `de_mode` low they are alternate names for status and control. With `de_mode` high they are not defined. The control register has a one-shot detect bit that turns the next access into a debug trap and then clears itself. Status and control both have bits that always read as one and bits that must be written as zero. The block also keeps a flag, `io_chk`, that tells the core whether any slot is enabled as an I/O-port watch. This lets the core skip port checks when no such slot is enabled.

Back-pressure: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever no response is pending, or when the pending response is being consumed in the same cycle. The response appears one cycle after acceptance. It stays unchanged until a clock edge sees `rsp_valid` and `rsp_ready` both high. Every accepted request gives exactly one response.

Top module: `dbgc_access_ctrl`

## Requirements
- R1: After reset, slots 0 to 3 read as 0, status (index 6) reads 0xFFFF0FF0, control (index 7) reads 0x00000400, `io_chk` is 0 and no response is pending. Exception codes are 0 for none, 1 for debug trap, 2 for undefined access and 3 for protection fault.
- R2: When no check fires, a write to index 0, 1, 2 or 3 stores the data unchanged in that slot, and a read of the slot returns it.
- R3: With `de_mode` low, index 4 accesses status and index 5 accesses control, for both reads and writes.
- R4: With `de_mode` high, an access to index 4 or 5 responds with code 2 and changes no register. This check has priority over all other checks, so it also leaves a set detect bit untouched.
- R5: When control bit 13 (detect) is set and R4 does not apply, an access responds with code 1 and is not performed. In that case control bit 13 is cleared and status bit 13 is set.
- R6: A write to status with bit 12 set, or a write to control with any of bits 11, 12, 14 or 15 set, responds with code 3 and does not update the register. R5 has priority over this check.
- R7: A write to status stores the data ORed with 0xFFFF0FF0. A write to control stores the data ORed with 0x00000400. These forced bits always read as one, and the control bits named in R6 always read as zero.
- R8: After a write to control, `io_chk` is 1 exactly when some slot n has control bit 2n or bit 2n+1 set and control bits [17+4n:16+4n] equal 2. `io_chk` changes only after an accepted write.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. A stalled response keeps its data and code. Response data is the register value for a read with code 0, and 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_idx | input | 3 | Register index |
| req_wdata | input | 32 | Write data |
| de_mode | input | 1 | Debug-extensions mode: high makes indices 4 and 5 undefined |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle |
| rsp_rdata | output | 32 | Read data |
| rsp_exc | output | 2 | Exception code |
| io_chk | output | 1 | Some slot is enabled as an I/O watch |

## Verification
The assertions check four things on every cycle:
- the forced-one and forced-zero bits of status and control;
- that a stalled response keeps its data and code;
- that an undefined-index access leaves both registers untouched and answers with code 2;
- that a detect trap clears the detect bit, sets the status flag and answers with code 1.

They also check that `io_chk` moves only after an accepted write.

Other behaviours need the bench's scenarios, because they depend on a sequence of accesses:
- that a trapped or faulted write really leaves the target unchanged, seen by reading it back later;
- that aliasing reaches the same storage as the direct indices;
- the order in which the checks take priority;
- the exact slot and type patterns that set `io_chk`.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int DBG_DW    = 32;
  localparam int DBG_IDX_W = 3;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_DEBUG = 2'd1,
    EXC_UNDEF = 2'd2,
    EXC_GPF   = 2'd3
  } exc_e;

  localparam logic [DBG_DW-1:0] STAT_FORCE1 = 32'hFFFF_0FF0;
  localparam logic [DBG_DW-1:0] STAT_RSV    = 32'h0000_1000;
  localparam logic [DBG_DW-1:0] CTRL_FORCE1 = 32'h0000_0400;
  localparam logic [DBG_DW-1:0] CTRL_RSV    = 32'h0000_D800;
  localparam int               STAT_BD_BIT = 13;
  localparam int               CTRL_GD_BIT = 13;
  localparam int               TYPE_LSB    = 16;
  localparam logic [1:0]       IO_TYPE     = 2'd2;
endpackage

// File: rtl/dbgc_index_map.sv
module dbgc_index_map #(
  parameter int IDX_W    = 3,
  parameter int ALIAS_LO = 4,
  parameter int ALIAS_HI = 5,
  parameter int ALIAS_OFS = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             de_mode,
  output logic [IDX_W-1:0] eff_idx,
  output logic             undef
);
  logic in_alias;

  always_comb begin
    in_alias = (idx >= IDX_W'(ALIAS_LO)) && (idx <= IDX_W'(ALIAS_HI));
    undef    = in_alias && de_mode;
    if (in_alias && !de_mode) eff_idx = idx + IDX_W'(ALIAS_OFS);
    else                      eff_idx = idx;
  end
endmodule

// File: rtl/dbgc_access_check.sv
module dbgc_access_check
  import dbgc_pkg::*;
#(
  parameter int               DW       = 32,
  parameter int               IDX_W    = 3,
  parameter int               STAT_IDX = 6,
  parameter int               CTRL_IDX = 7,
  parameter logic [DW-1:0]    S_RSV    = '0,
  parameter logic [DW-1:0]    C_RSV    = '0
) (
  input  logic             wr,
  input  logic [IDX_W-1:0] eff_idx,
  input  logic [DW-1:0]    wdata,
  input  logic             undef,
  input  logic             gd_set,
  output exc_e             exc,
  output logic             gd_trap
);
  logic rsv_hit;

  always_comb begin
    rsv_hit = 1'b0;
    if (wr && eff_idx == IDX_W'(STAT_IDX)) rsv_hit = |(wdata & S_RSV);
    if (wr && eff_idx == IDX_W'(CTRL_IDX)) rsv_hit = |(wdata & C_RSV);

    gd_trap = !undef && gd_set;

    if (undef)        exc = EXC_UNDEF;
    else if (gd_set)  exc = EXC_DEBUG;
    else if (rsv_hit) exc = EXC_GPF;
    else              exc = EXC_NONE;
  end
endmodule

// File: rtl/dbgc_reg_bank.sv
module dbgc_reg_bank #(
  parameter int            DW        = 32,
  parameter int            IDX_W     = 3,
  parameter int            NUM_SLOTS = 4,
  parameter int            STAT_IDX  = 6,
  parameter int            CTRL_IDX  = 7,
  parameter logic [DW-1:0] S_FORCE1  = '0,
  parameter logic [DW-1:0] C_FORCE1  = '0,
  parameter int            BD_BIT    = 13,
  parameter int            GD_BIT    = 13,
  parameter int            T_LSB     = 16,
  parameter logic [1:0]    IO_CODE   = 2'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             trap_en,
  input  logic [IDX_W-1:0] eff_idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [DW-1:0]    stat_q,
  output logic [DW-1:0]    ctrl_q,
  output logic             io_chk_q
);
  localparam int EN_W  = 2;
  localparam int FLD_W = 4;

  logic [DW-1:0]        slot_q [NUM_SLOTS];
  logic [DW-1:0]        ctrl_next;
  logic [NUM_SLOTS-1:0] io_hit;

  assign ctrl_next = wdata | C_FORCE1;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                     slot_q[s] <= '0;
      else if (wr_en && eff_idx == IDX_W'(s))         slot_q[s] <= wdata;
    end
    assign io_hit[s] = (|ctrl_next[EN_W*s +: EN_W]) &&
                       (ctrl_next[T_LSB + FLD_W*s +: 2] == IO_CODE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q   <= S_FORCE1;
      ctrl_q   <= C_FORCE1;
      io_chk_q <= 1'b0;
    end else if (trap_en) begin
      stat_q[BD_BIT] <= 1'b1;
      ctrl_q[GD_BIT] <= 1'b0;
    end else if (wr_en) begin
      if (eff_idx == IDX_W'(STAT_IDX)) stat_q <= wdata | S_FORCE1;
      if (eff_idx == IDX_W'(CTRL_IDX)) begin
        ctrl_q   <= ctrl_next;
        io_chk_q <= |io_hit;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (eff_idx == IDX_W'(STAT_IDX))      rdata = stat_q;
    else if (eff_idx == IDX_W'(CTRL_IDX)) rdata = ctrl_q;
    else begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (eff_idx == IDX_W'(s)) rdata = slot_q[s];
    end
  end
endmodule

// File: rtl/dbgc_access_ctrl.sv
module dbgc_access_ctrl
  import dbgc_pkg::*;
#(
  parameter int DW        = DBG_DW,
  parameter int IDX_W     = DBG_IDX_W,
  parameter int NUM_SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_wr,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [DW-1:0]    req_wdata,
  input  logic             de_mode,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [DW-1:0]    rsp_rdata,
  output logic [1:0]       rsp_exc,
  output logic             io_chk
);
  localparam int STAT_IDX = 6;
  localparam int CTRL_IDX = 7;

  logic             acc;
  logic [IDX_W-1:0] eff_idx;
  logic             undef;
  exc_e             exc;
  logic             gd_trap;
  logic [DW-1:0]    bank_rdata;
  logic [DW-1:0]    stat_q;
  logic [DW-1:0]    ctrl_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  dbgc_index_map #(.IDX_W(IDX_W), .ALIAS_LO(4), .ALIAS_HI(5), .ALIAS_OFS(2)) u_map (
    .idx(req_idx), .de_mode(de_mode), .eff_idx(eff_idx), .undef(undef)
  );

  dbgc_access_check #(
    .DW(DW), .IDX_W(IDX_W), .STAT_IDX(STAT_IDX), .CTRL_IDX(CTRL_IDX),
    .S_RSV(STAT_RSV), .C_RSV(CTRL_RSV)
  ) u_chk_logic (
    .wr(req_wr), .eff_idx(eff_idx), .wdata(req_wdata), .undef(undef),
    .gd_set(ctrl_q[CTRL_GD_BIT]), .exc(exc), .gd_trap(gd_trap)
  );

  dbgc_reg_bank #(
    .DW(DW), .IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS),
    .STAT_IDX(STAT_IDX), .CTRL_IDX(CTRL_IDX),
    .S_FORCE1(STAT_FORCE1), .C_FORCE1(CTRL_FORCE1),
    .BD_BIT(STAT_BD_BIT), .GD_BIT(CTRL_GD_BIT),
    .T_LSB(TYPE_LSB), .IO_CODE(IO_TYPE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc && req_wr && exc == EXC_NONE),
    .trap_en(acc && gd_trap),
    .eff_idx(eff_idx), .wdata(req_wdata), .rdata(bank_rdata),
    .stat_q(stat_q), .ctrl_q(ctrl_q), .io_chk_q(io_chk)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_exc   <= EXC_NONE;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_exc   <= exc;
      rsp_rdata <= (exc == EXC_NONE && !req_wr) ? bank_rdata : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dbgc_access_ctrl_chk.sv
module dbgc_access_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_wr,
  input logic [2:0]  req_idx,
  input logic        de_mode,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [1:0]  rsp_exc,
  input logic        io_chk,
  input logic [31:0] stat_q,
  input logic [31:0] ctrl_q
);
  logic acc;
  logic undef_req;
  assign acc       = req_valid && req_ready;
  assign undef_req = de_mode && (req_idx == 3'd4 || req_idx == 3'd5);

  AST_STAT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & 32'hFFFF_0FF0) == 32'hFFFF_0FF0);                             // R7
  AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[10] && ((ctrl_q & 32'h0000_D800) == 32'h0));                    // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_exc))); // R9
  AST_UNDEF_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && undef_req) |=> (rsp_valid && rsp_exc == 2'd2 && $stable(ctrl_q) && $stable(stat_q))); // R4
  AST_GD_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !undef_req && ctrl_q[13]) |=> (rsp_exc == 2'd1 && !ctrl_q[13] && stat_q[13])); // R5
  AST_IOCHK_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (io_chk != $past(io_chk)) |-> $past(acc && req_wr));                    // R8
  AST_EXC_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_exc != 2'd0) |-> (rsp_rdata == 32'h0));               // R9
endmodule

bind dbgc_access_ctrl dbgc_access_ctrl_chk u_access_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_wr(req_wr), .req_idx(req_idx), .de_mode(de_mode),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .rsp_exc(rsp_exc), .io_chk(io_chk), .stat_q(stat_q), .ctrl_q(ctrl_q)
);

// File: tb/dbgc_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbgc_access_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_wr = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic        de_mode = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_exc;
  logic        io_chk;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dbgc_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_idx(req_idx), .req_wdata(req_wdata), .de_mode(de_mode),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_exc(rsp_exc), .io_chk(io_chk)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=20000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  logic [31:0] got_data;
  logic [1:0]  got_exc;

  task automatic access(input logic wr, input logic [2:0] idx, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_idx = idx; req_wdata = data;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    got_data = rsp_rdata;
    got_exc  = rsp_exc;
    if (!rsp_valid) check("R9 response after accept", 32'(rsp_valid), 32'd1);
  endtask

  task automatic expect_read(input string req, input logic [2:0] idx, input logic [31:0] exp);
    access(1'b0, idx, 32'h0);
    check(req, {30'd0, got_exc}, 32'd0);
    check(req, got_data, exp);
  endtask

  task automatic t_reset;
    check("R1 io_chk reset", 32'(io_chk), 32'd0);
    check("R1 rsp_valid reset", 32'(rsp_valid), 32'd0);
    expect_read("R1 slot0 reset", 3'd0, 32'h0);
    expect_read("R1 slot3 reset", 3'd3, 32'h0);
    expect_read("R1 status reset", 3'd6, 32'hFFFF_0FF0);
    expect_read("R1 control reset", 3'd7, 32'h0000_0400);
  endtask

  task automatic t_slots;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 3'(i), 32'hA5A5_0000 + 32'(i * 17));
      check("R2 slot write code", {30'd0, got_exc}, 32'd0);
      check("R9 write data zero", got_data, 32'h0);
    end
    for (int i = 0; i < 4; i++)
      expect_read("R2 slot readback", 3'(i), 32'hA5A5_0000 + 32'(i * 17));
  endtask

  task automatic t_forced;
    access(1'b1, 3'd6, 32'h0000_0000);
    expect_read("R7 status forced ones", 3'd6, 32'hFFFF_0FF0);
    access(1'b1, 3'd7, 32'h0000_0000);
    expect_read("R7 control forced one", 3'd7, 32'h0000_0400);
  endtask

  task automatic t_alias;
    de_mode = 1'b0;
    access(1'b1, 3'd5, 32'h0000_0001);
    check("R3 alias 5 write code", {30'd0, got_exc}, 32'd0);
    expect_read("R3 ctrl via 7", 3'd7, 32'h0000_0401);
    expect_read("R3 ctrl via 5", 3'd5, 32'h0000_0401);
    access(1'b1, 3'd4, 32'h0000_000F);
    expect_read("R3 status via 6", 3'd6, 32'hFFFF_0FFF);
    expect_read("R3 status via 4", 3'd4, 32'hFFFF_0FFF);
  endtask

  task automatic t_undef;
    de_mode = 1'b1;
    access(1'b0, 3'd4, 32'h0);
    check("R4 read 4 code", {30'd0, got_exc}, 32'd2);
    check("R9 exc data zero", got_data, 32'h0);
    access(1'b1, 3'd5, 32'h0000_0003);
    check("R4 write 5 code", {30'd0, got_exc}, 32'd2);
    de_mode = 1'b0;
    expect_read("R4 ctrl unchanged", 3'd7, 32'h0000_0401);
  endtask

  task automatic t_reserved;
    access(1'b1, 3'd7, 32'h0000_0800);
    check("R6 ctrl bit11 code", {30'd0, got_exc}, 32'd3);
    access(1'b1, 3'd7, 32'h0000_4001);
    check("R6 ctrl bit14 code", {30'd0, got_exc}, 32'd3);
    expect_read("R6 ctrl unchanged", 3'd7, 32'h0000_0401);
    access(1'b1, 3'd6, 32'h0000_1000);
    check("R6 status bit12 code", {30'd0, got_exc}, 32'd3);
    expect_read("R6 status unchanged", 3'd6, 32'hFFFF_0FFF);
  endtask

  task automatic t_iochk;
    access(1'b1, 3'd7, 32'h0200_0010);
    check("R8 slot2 local io", 32'(io_chk), 32'd1);
    access(1'b1, 3'd7, 32'h0200_0000);
    check("R8 slot2 disabled", 32'(io_chk), 32'd0);
    access(1'b1, 3'd7, 32'h2000_0080);
    check("R8 slot3 global io", 32'(io_chk), 32'd1);
    access(1'b0, 3'd7, 32'h0);
    check("R8 read keeps flag", 32'(io_chk), 32'd1);
    access(1'b1, 3'd7, 32'h0001_0001);
    check("R8 slot0 write type", 32'(io_chk), 32'd0);
  endtask

  task automatic t_gd;
    access(1'b1, 3'd6, 32'h0);
    access(1'b1, 3'd0, 32'h0000_1111);
    access(1'b1, 3'd7, 32'h0000_2000);
    access(1'b1, 3'd0, 32'h0000_0055);
    check("R5 trap code", {30'd0, got_exc}, 32'd1);
    expect_read("R5 slot not written", 3'd0, 32'h0000_1111);
    expect_read("R5 detect cleared", 3'd7, 32'h0000_0400);
    expect_read("R5 status flag", 3'd6, 32'hFFFF_2FF0);
    access(1'b1, 3'd7, 32'h0000_2000);
    access(1'b1, 3'd7, 32'h0000_0800);
    check("R6 detect before reserved", {30'd0, got_exc}, 32'd1);
    access(1'b1, 3'd7, 32'h0000_2000);
    de_mode = 1'b1;
    access(1'b0, 3'd4, 32'h0);
    check("R4 undef before detect", {30'd0, got_exc}, 32'd2);
    de_mode = 1'b0;
    access(1'b0, 3'd7, 32'h0);
    check("R4 detect still armed", {30'd0, got_exc}, 32'd1);
    expect_read("R5 control after trap", 3'd7, 32'h0000_0400);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_wr = 1'b0; req_idx = 3'd0; req_wdata = 32'h0;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 stalled valid", 32'(rsp_valid), 32'd1);
      check("R9 stalled ready", 32'(req_ready), 32'd0);
      check("R9 stalled data", rsp_rdata, 32'h0000_1111);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 ready with consume", 32'(req_ready), 32'd1);
    @(negedge clk);
    check("R9 response drained", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_slots();
    t_forced();
    t_alias();
    t_undef();
    t_reserved();
    t_iochk();
    t_gd();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule